// File: doc/BRIEF.md
# Pipelined Cartesian/Polar CORDIC Converter

This block is a fully unrolled, pipelined CORDIC engine that turns samples from rectangular to polar form and back, using only shifts and additions. A mode bit travels with each sample, so rectangular-to-polar (vectoring) and polar-to-rectangular (rotation) conversions share one datapath and can be mixed freely from one clock to the next. It takes one sample per clock and returns one result per clock after a fixed latency of `ITER + 3` cycles.

The shift-add iterations can only reach angles within a quarter turn either side of zero. A folding stage in front handles the rest of the circle. In vectoring mode it mirrors left-half-plane vectors through the origin. In rotation mode it takes half a turn off large angles. A finishing stage then undoes the fold, removes the CORDIC gain with a fixed shift-add multiply, rounds and saturates. Angles are signed fractions of half a turn: a code of 2^(W-1) stands for 180 degrees, and the code wraps modulo 2^W.

Top module: `cordic_polar_conv`

## Requirements
- R1: With `in_mode` = 0 (to polar), `out_x` equals round(sqrt(in_x^2 + in_y^2)) within 3 LSB and is never negative.
- R2: With `in_mode` = 0 and `in_z` = 0, for vectors of magnitude at least 2^(W-3), `out_z` equals atan2(in_y, in_x) * 2^(W-1)/pi within 3 LSB, compared modulo 2^W. This holds in all four quadrants and on the negative x axis.
- R3: With `in_mode` = 1 (to rectangular) and `in_y` = 0, `out_x` = in_x*cos(a) and `out_y` = in_x*sin(a) within 3 LSB, where a = in_z*pi/2^(W-1). This holds for any angle code, including exactly +90 degrees and -180 degrees.
- R4: A sample presented with `in_vld` high appears with `out_vld` high exactly `ITER + 3` clocks later. A cycle with `in_vld` low yields a cycle with `out_vld` low, and back-to-back samples give back-to-back results.
- R5: Each sample is converted in the mode it entered with, even when the mode changes on every clock.
- R6: In mode 0, a magnitude above 2^(W-1)-1 drives `out_x` to exactly 2^(W-1)-1.
- R7: While `rst_n` is low, and for the `ITER + 3` clocks after it rises with no valid input, `out_vld` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input sample valid |
| in_mode | input | 1 | 0: rectangular to polar, 1: polar to rectangular |
| in_x | input | W | Signed x component, or magnitude in mode 1 |
| in_y | input | W | Signed y component (0 in mode 1) |
| in_z | input | W | Angle code in mode 1, 0 in mode 0 |
| out_vld | output | 1 | Output sample valid |
| out_x | output | W | Magnitude (mode 0) or x component (mode 1) |
| out_y | output | W | Residual near 0 (mode 0) or y component (mode 1) |
| out_z | output | W | Angle code (mode 0) or residual near 0 (mode 1) |

## Verification
Vectors on the four axes and in every quadrant show whether the fold and the half-turn correction pick the right half-plane. Rotation angles at exactly +90, -180 and just short of +180 probe the edges of the angle reduction. Saturating vectors separate clamping from wrap-around. Random rectangular and polar samples, some back to back with alternating modes and some broken by idle cycles, expose mode or valid bits that drift out of step with their data, and show how much error the gain removal adds.

// File: rtl/cordic_pkg.sv
`timescale 1ns/1ps
package cordic_pkg;

    typedef enum logic {
        CONV_TO_POLAR = 1'b0,
        CONV_TO_RECT  = 1'b1
    } conv_mode_e;

    // atan(2^-idx) expressed as a fraction of pi, scaled by 2^31
    function automatic longint atan_frac31(input int idx);
        longint v;
        case (idx)
            0:       v = 64'sd536870912;
            1:       v = 64'sd316933406;
            2:       v = 64'sd167458907;
            3:       v = 64'sd85004756;
            4:       v = 64'sd42667331;
            5:       v = 64'sd21354465;
            6:       v = 64'sd10679838;
            7:       v = 64'sd5340245;
            8:       v = 64'sd2670163;
            9:       v = 64'sd1335087;
            10:      v = 64'sd667544;
            11:      v = 64'sd333772;
            12:      v = 64'sd166886;
            default: v = 64'sd683565276 >>> idx;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cordic_fold.sv
`timescale 1ns/1ps
module cordic_fold #(
    parameter int W = 16,
    parameter int G = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic                    in_mode,
    input  logic signed [W-1:0]     in_x,
    input  logic signed [W-1:0]     in_y,
    input  logic signed [W-1:0]     in_z,
    output logic                    o_vld,
    output logic                    o_mode,
    output logic                    o_fix,
    output logic signed [W+1+G:0]   o_x,
    output logic signed [W+1+G:0]   o_y,
    output logic signed [W+G-1:0]   o_z
);
    import cordic_pkg::*;

    localparam int IW = W + 2 + G;
    localparam int AW = W + G;

    typedef struct packed {
        logic                 vld;
        logic                 mode;
        logic                 fix;
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
        logic signed [AW-1:0] z;
    } fold_t;

    fold_t st_d, st_q;
    logic signed [IW-1:0] xe, ye;

    always_comb begin
        xe        = {{2{in_x[W-1]}}, in_x, {G{1'b0}}};
        ye        = {{2{in_y[W-1]}}, in_y, {G{1'b0}}};
        st_d.vld  = in_vld;
        st_d.mode = in_mode;
        st_d.fix  = 1'b0;
        st_d.x    = xe;
        st_d.y    = ye;
        st_d.z    = {in_z, {G{1'b0}}};
        if (conv_mode_e'(in_mode) == CONV_TO_POLAR) begin
            if (in_x[W-1]) begin
                st_d.x   = -xe;
                st_d.y   = -ye;
                st_d.fix = 1'b1;
            end
        end else if (in_z[W-1] ^ in_z[W-2]) begin
            st_d.z   = {~in_z[W-1], in_z[W-2:0], {G{1'b0}}};
            st_d.fix = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign o_vld  = st_q.vld;
    assign o_mode = st_q.mode;
    assign o_fix  = st_q.fix;
    assign o_x    = st_q.x;
    assign o_y    = st_q.y;
    assign o_z    = st_q.z;

    AST_FOLD_X_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && !st_q.mode) |-> !st_q.x[IW-1]); // R1
    AST_FOLD_Z_QUARTER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.mode) |-> (st_q.z[AW-1] == st_q.z[AW-2])); // R3

endmodule

// File: rtl/cordic_step.sv
`timescale 1ns/1ps
module cordic_step #(
    parameter int W   = 16,
    parameter int G   = 5,
    parameter int IDX = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    i_vld,
    input  logic                    i_mode,
    input  logic                    i_fix,
    input  logic signed [W+1+G:0]   i_x,
    input  logic signed [W+1+G:0]   i_y,
    input  logic signed [W+G-1:0]   i_z,
    output logic                    o_vld,
    output logic                    o_mode,
    output logic                    o_fix,
    output logic signed [W+1+G:0]   o_x,
    output logic signed [W+1+G:0]   o_y,
    output logic signed [W+G-1:0]   o_z
);
    import cordic_pkg::*;

    localparam int IW = W + 2 + G;
    localparam int AW = W + G;
    localparam longint RAW = atan_frac31(IDX);
    localparam logic signed [AW-1:0] ANG =
        AW'((RAW + (64'sd1 <<< (31 - AW))) >>> (32 - AW));
    localparam logic signed [AW-1:0] QTR = AW'(64'sd1 <<< (AW - 2));

    typedef struct packed {
        logic                 vld;
        logic                 mode;
        logic                 fix;
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
        logic signed [AW-1:0] z;
    } step_t;

    step_t st_d, st_q;
    logic signed [IW-1:0] xs, ys;
    logic rot_ccw;

    always_comb begin
        xs        = i_x >>> IDX;
        ys        = i_y >>> IDX;
        rot_ccw   = i_mode ? ~i_z[AW-1] : i_y[IW-1];
        st_d.vld  = i_vld;
        st_d.mode = i_mode;
        st_d.fix  = i_fix;
        if (rot_ccw) begin
            st_d.x = i_x - ys;
            st_d.y = i_y + xs;
            st_d.z = i_z - ANG;
        end else begin
            st_d.x = i_x + ys;
            st_d.y = i_y - xs;
            st_d.z = i_z + ANG;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign o_vld  = st_q.vld;
    assign o_mode = st_q.mode;
    assign o_fix  = st_q.fix;
    assign o_x    = st_q.x;
    assign o_y    = st_q.y;
    assign o_z    = st_q.z;

    AST_STEP_X_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && !st_q.mode) |-> !st_q.x[IW-1]); // R1
    AST_STEP_Z_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.mode) |-> ($signed(st_q.z) <= QTR && $signed(st_q.z) >= -QTR)); // R3

endmodule

// File: rtl/cordic_finish.sv
`timescale 1ns/1ps
module cordic_finish #(
    parameter int W = 16,
    parameter int G = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    i_vld,
    input  logic                    i_mode,
    input  logic                    i_fix,
    input  logic signed [W+1+G:0]   i_x,
    input  logic signed [W+1+G:0]   i_y,
    input  logic signed [W+G-1:0]   i_z,
    output logic                    o_vld,
    output logic signed [W-1:0]     o_x,
    output logic signed [W-1:0]     o_y,
    output logic signed [W-1:0]     o_z
);
    localparam int IW = W + 2 + G;
    localparam int AW = W + G;
    localparam logic signed [IW-1:0] RND  = IW'(2 ** (G - 1));
    localparam logic signed [AW-1:0] ZRND = AW'(2 ** (G - 1));
    localparam logic signed [W+1:0]  PMAX = (W+2)'(2 ** (W - 1) - 1);
    localparam logic signed [W+1:0]  NMIN = -((W+2)'(2 ** (W - 1)));

    typedef struct packed {
        logic                 vld;
        logic                 mode;
        logic                 fix;
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
        logic signed [AW-1:0] z;
    } gain_t;

    typedef struct packed {
        logic                vld;
        logic                mode;
        logic signed [W-1:0] x;
        logic signed [W-1:0] y;
        logic signed [W-1:0] z;
    } out_t;

    // multiply by ~0.607254 (inverse CORDIC gain) with shifts and adds
    function automatic logic signed [IW-1:0] gain_fix(input logic signed [IW-1:0] v);
        return (v >>> 1) + (v >>> 3) - (v >>> 6) - (v >>> 9)
             - (v >>> 12) + (v >>> 14) + (v >>> 16);
    endfunction

    function automatic logic signed [W-1:0] clamp(input logic signed [W+1:0] v);
        if (v > PMAX)      return PMAX[W-1:0];
        else if (v < NMIN) return NMIN[W-1:0];
        else               return v[W-1:0];
    endfunction

    gain_t ga_d, ga_q;
    out_t  ou_d, ou_q;
    logic signed [IW-1:0] xa, ya, xr, yr;
    logic signed [AW-1:0] zr;

    always_comb begin
        ga_d.vld  = i_vld;
        ga_d.mode = i_mode;
        ga_d.fix  = i_fix;
        ga_d.x    = gain_fix(i_x);
        ga_d.y    = gain_fix(i_y);
        ga_d.z    = (!i_mode && i_fix) ? {~i_z[AW-1], i_z[AW-2:0]} : i_z;

        xa        = (ga_q.mode && ga_q.fix) ? -ga_q.x : ga_q.x;
        ya        = (ga_q.mode && ga_q.fix) ? -ga_q.y : ga_q.y;
        xr        = xa + RND;
        yr        = ya + RND;
        zr        = ga_q.z + ZRND;
        ou_d.vld  = ga_q.vld;
        ou_d.mode = ga_q.mode;
        ou_d.x    = clamp(xr[IW-1:G]);
        ou_d.y    = clamp(yr[IW-1:G]);
        ou_d.z    = zr[AW-1:G];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ga_q <= '0;
            ou_q <= '0;
        end else begin
            ga_q <= ga_d;
            ou_q <= ou_d;
        end
    end

    assign o_vld = ou_q.vld;
    assign o_x   = ou_q.x;
    assign o_y   = ou_q.y;
    assign o_z   = ou_q.z;

    AST_MAG_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (ou_q.vld && !ou_q.mode) |-> !ou_q.x[W-1]); // R1

endmodule

// File: rtl/cordic_polar_conv.sv
`timescale 1ns/1ps
module cordic_polar_conv #(
    parameter int W    = 16,
    parameter int ITER = 18,
    parameter int G    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic                in_mode,
    input  logic signed [W-1:0] in_x,
    input  logic signed [W-1:0] in_y,
    input  logic signed [W-1:0] in_z,
    output logic                out_vld,
    output logic signed [W-1:0] out_x,
    output logic signed [W-1:0] out_y,
    output logic signed [W-1:0] out_z
);
    localparam int IW = W + 2 + G;
    localparam int AW = W + G;

    logic                 sv [0:ITER];
    logic                 sm [0:ITER];
    logic                 sf [0:ITER];
    logic signed [IW-1:0] sx [0:ITER];
    logic signed [IW-1:0] sy [0:ITER];
    logic signed [AW-1:0] sz [0:ITER];

    cordic_fold #(.W(W), .G(G)) u_fold (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_vld), .in_mode(in_mode),
        .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .o_vld(sv[0]), .o_mode(sm[0]), .o_fix(sf[0]),
        .o_x(sx[0]), .o_y(sy[0]), .o_z(sz[0])
    );

    for (genvar g = 0; g < ITER; g++) begin : g_step
        cordic_step #(.W(W), .G(G), .IDX(g)) u_step (
            .clk(clk), .rst_n(rst_n),
            .i_vld(sv[g]), .i_mode(sm[g]), .i_fix(sf[g]),
            .i_x(sx[g]), .i_y(sy[g]), .i_z(sz[g]),
            .o_vld(sv[g+1]), .o_mode(sm[g+1]), .o_fix(sf[g+1]),
            .o_x(sx[g+1]), .o_y(sy[g+1]), .o_z(sz[g+1])
        );
    end

    cordic_finish #(.W(W), .G(G)) u_finish (
        .clk(clk), .rst_n(rst_n),
        .i_vld(sv[ITER]), .i_mode(sm[ITER]), .i_fix(sf[ITER]),
        .i_x(sx[ITER]), .i_y(sy[ITER]), .i_z(sz[ITER]),
        .o_vld(out_vld), .o_x(out_x), .o_y(out_y), .o_z(out_z)
    );

    AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> !$isunknown({out_x, out_y, out_z})); // R4

endmodule

// File: tb/tb_cordic_polar_conv.sv
`timescale 1ns/1ps
module tb_cordic_polar_conv;
    localparam int  W    = 16;
    localparam int  ITER = 18;
    localparam int  LAT  = ITER + 3;
    localparam int  FULL = 32768;
    localparam real PI   = 3.14159265358979;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0, in_mode = 1'b0;
    logic signed [W-1:0] in_x = '0, in_y = '0, in_z = '0;
    logic out_vld;
    logic signed [W-1:0] out_x, out_y, out_z;

    always #2.5 clk = ~clk;

    cordic_polar_conv #(.W(W), .ITER(ITER)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_vld), .in_mode(in_mode),
        .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .out_vld(out_vld), .out_x(out_x), .out_y(out_y), .out_z(out_z)
    );

    typedef struct {
        bit vld; bit mode; bit ang_ok; bit sat; bit inter;
        int ex; int ey; int ez;
    } exp_t;

    exp_t pend[$];
    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    function automatic int rnd(input real r);
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    endfunction

    function automatic int wrap_dist(input int a, input int b);
        int d;
        d = a - b;
        d = ((d % 65536) + 65536) % 65536;
        if (d >= FULL) d = d - 65536;
        return (d < 0) ? -d : d;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int got, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, expv);
        end
    endtask

    task automatic compare_out();
        exp_t e;
        if (pend.size() < LAT) begin
            chk(out_vld == 1'b0, "R7", "valid before first result", int'(out_vld), 0);
            return;
        end
        e = pend.pop_front();
        chk(out_vld == e.vld, "R4", "output valid", int'(out_vld), int'(e.vld));
        if (e.vld && out_vld) begin
            if (!e.mode) begin
                if (e.sat) chk(out_x == 16'sd32767, "R6", "saturated magnitude", int'(out_x), 32767);
                else chk(wrap_dist(out_x, e.ex) <= 3, e.inter ? "R5" : "R1", "magnitude", int'(out_x), e.ex);
                if (e.ang_ok) chk(wrap_dist(out_z, e.ez) <= 3, e.inter ? "R5" : "R2", "angle", int'(out_z), e.ez);
            end else begin
                chk(wrap_dist(out_x, e.ex) <= 3, e.inter ? "R5" : "R3", "rect x", int'(out_x), e.ex);
                chk(wrap_dist(out_y, e.ey) <= 3, e.inter ? "R5" : "R3", "rect y", int'(out_y), e.ey);
            end
        end
    endtask

    task automatic send(input bit v, input bit m, input int x, input int y, input int z, input bit inter);
        exp_t e;
        real mag, ang;
        @(negedge clk);
        compare_out();
        in_vld  = v;
        in_mode = m;
        in_x    = W'(x);
        in_y    = W'(y);
        in_z    = W'(z);
        e.vld = v; e.mode = m; e.inter = inter;
        e.ang_ok = 1'b0; e.sat = 1'b0; e.ex = 0; e.ey = 0; e.ez = 0;
        if (!m) begin
            mag = $sqrt(real'(x) * real'(x) + real'(y) * real'(y));
            e.ex = rnd(mag);
            if (e.ex > 32767) begin e.sat = 1'b1; e.ex = 32767; end
            e.ang_ok = (mag >= 4096.0);
            e.ez = rnd($atan2(real'(y), real'(x)) / PI * FULL) + z;
        end else begin
            ang = real'(z) * PI / FULL;
            e.ex = rnd(real'(x) * $cos(ang) - real'(y) * $sin(ang));
            e.ey = rnd(real'(x) * $sin(ang) + real'(y) * $cos(ang));
        end
        pend.push_back(e);
    endtask

    task automatic rand_polar(input bit inter);
        int x, y;
        do begin
            x = int'($urandom_range(40000)) - 20000;
            y = int'($urandom_range(40000)) - 20000;
        end while (x * x + y * y < 8192 * 8192);
        send(1'b1, 1'b0, x, y, 0, inter);
    endtask

    task automatic rand_rect(input bit inter);
        send(1'b1, 1'b1, int'($urandom_range(30000)), 0, int'($urandom_range(65535)) - FULL, inter);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL R4 watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R7: reset holds valid low
        repeat (4) begin
            @(negedge clk);
            chk(out_vld == 1'b0, "R7", "valid in reset", int'(out_vld), 0);
        end
        rst_n = 1'b1;

        // R1 R2: axes and all quadrants
        send(1, 0,  20000,  10000, 0, 0);
        send(1, 0, -20000,  10000, 0, 0);
        send(1, 0, -20000, -10000, 0, 0);
        send(1, 0,  20000, -10000, 0, 0);
        send(1, 0,      0,  25000, 0, 0);
        send(1, 0, -25000,      0, 0, 0);
        send(1, 0,      0, -25000, 0, 0);
        send(1, 0,  30000,      0, 0, 0);
        send(1, 0,      3,     -4, 0, 0);
        send(1, 0, -32768,   1000, 0, 0);
        // R6: over-range magnitudes
        send(1, 0,  32000,  32000, 0, 0);
        send(1, 0, -32768, -32768, 0, 0);
        // R3: rotation corners
        send(1, 1, 30000, 0,      0, 0);
        send(1, 1, 30000, 0,   8192, 0);
        send(1, 1, 30000, 0,  16384, 0);
        send(1, 1, 30000, 0,  18204, 0);
        send(1, 1, 30000, 0, -24576, 0);
        send(1, 1, 30000, 0, -32768, 0);
        send(1, 1, 30000, 0,  32585, 0);
        send(1, 1, 32767, 0,      0, 0);
        send(1, 1, 12345, 0, -16384, 0);
        // R4: idle gap then back-to-back stream
        repeat (5) send(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 150; i++) rand_polar(1'b0);
        for (int i = 0; i < 150; i++) rand_rect(1'b0);
        // R5: mode toggles every clock, with occasional bubbles
        for (int i = 0; i < 60; i++) begin
            if (i % 7 == 6) send(0, 1, 0, 0, 0, 1);
            else if (i % 2 == 0) rand_polar(1'b1);
            else rand_rect(1'b1);
        end
        repeat (LAT + 3) send(0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule